// File: doc/BRIEF.md
# Wide Screen Signalling Decoder

This block recovers the 14-bit wide screen signalling word from one chosen video line. An upstream slicer delivers a stream of half-bit samples, each marked by a valid strobe, together with the current line number and a strobe at the start of every line. On the signalling line, while acquisition is enabled, the block first checks a fixed start code. It then decodes fourteen biphase bits, least significant bit first.

The decoded bits fall into four groups of related meaning: picture format, service/camera mode, subtitles, and spare. Each group carries its own error flag, which reports a broken biphase pair anywhere in that group. The groups are packed into three 8-bit status registers. The registers change in a single step once the last bit of a complete word has arrived, so a reader never sees a mix of old and new bits. A sticky received flag marks each successful capture, and software clears it with a one-cycle clear pulse.

Top module: `wss_decoder`

## Requirements
- R1: Only the line whose number equals parameter WSS_LINE (default 23) is decoded; samples on any other line leave the registers and the received flag unchanged.
- R2: A word is exactly 14 bits, sent bit 0 first. Each bit is two consecutive valid half-bits, and the bit's value is the first half (pair 1,0 gives 1; pair 0,1 gives 0).
- R3: Register layout: fmt_reg[3:0] = bits 3..0 and fmt_reg[4] = group 0 error. svc_reg[3:0] = bits 7..4 and svc_reg[4] = group 1 error. sub_reg[2:0] = bits 10..8, sub_reg[3] = group 2 error, sub_reg[6:4] = bits 13..11 and sub_reg[7] = group 3 error. All other bits read 0.
- R4: A group's error flag is 1 when at least one pair in that group has two equal halves, and 0 otherwise. The bit still takes the value of its first half.
- R5: acq_en is sampled at the line-start strobe. When it is low there, that line is ignored.
- R6: wss_seen becomes 1 on each completed capture and stays 1 until a flag_clr pulse. If a capture and a clear fall in the same cycle, the capture wins.
- R7: The line must open with the START_W half-bits of START_CODE, most significant first (default 8'b1110_0100). On any mismatch the rest of the line is ignored: no register change and no flag.
- R8: The registers and the flag update together, two clock edges after the last half-bit is accepted. A line-start strobe before the 14th bit discards the partial word and keeps the old values.
- R9: After reset all three registers and wss_seen are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_num | input | LINE_W | Number of the current video line |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| acq_en | input | 1 | Acquisition enable, sampled at line_start |
| hb_valid | input | 1 | Strobe marking a valid half-bit sample |
| hb_data | input | 1 | Sliced half-bit value |
| flag_clr | input | 1 | One-cycle pulse that clears wss_seen |
| fmt_reg | output | 8 | Format group bits and their error flag |
| svc_reg | output | 8 | Service/mode group bits and their error flag |
| sub_reg | output | 8 | Subtitle and spare groups with their error flags |
| wss_seen | output | 1 | Sticky received flag |

## Verification
A receiver that misses a start-code mismatch shows up at the ports: the next line with a corrupted start code would still change the registers. A bit counter that is off by one moves every field across a group boundary, which the registers show two edges after the end of the line. An error accumulator that fails to restart at a group's first bit either keeps a stale error flag or drops a real one, and the very next capture exposes it. A partial word leaking through shows after a truncated line as changed registers with no flag.

// File: rtl/wss_pkg.sv
package wss_pkg;
  localparam int NBITS   = 14;
  localparam int NGROUPS = 4;
  localparam int REG_W   = 8;
  localparam int BIDX_W  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA} rx_state_t;

  // group number of a bit index
  function automatic logic [1:0] group_of(input logic [BIDX_W-1:0] idx);
    if (idx < 4'd4)       return 2'd0;
    else if (idx < 4'd8)  return 2'd1;
    else if (idx < 4'd11) return 2'd2;
    else                  return 2'd3;
  endfunction

  // true for the first bit of each group
  function automatic logic group_head(input logic [BIDX_W-1:0] idx);
    return (idx == 4'd0) || (idx == 4'd4) || (idx == 4'd8) || (idx == 4'd11);
  endfunction

  // place the groups into the three status registers {sub, svc, fmt}
  function automatic logic [3*REG_W-1:0] pack_regs(input logic [NBITS-1:0]   b,
                                                   input logic [NGROUPS-1:0] e);
    logic [3*REG_W-1:0] r;
    r        = '0;
    r[3:0]   = b[3:0];
    r[4]     = e[0];
    r[11:8]  = b[7:4];
    r[12]    = e[1];
    r[18:16] = b[10:8];
    r[19]    = e[2];
    r[22:20] = b[13:11];
    r[23]    = e[3];
    return r;
  endfunction
endpackage

// File: rtl/wss_frame_rx.sv
module wss_frame_rx
  import wss_pkg::*;
#(
  parameter int             LINE_W     = 10,
  parameter int             WSS_LINE   = 23,
  parameter int             START_W    = 8,
  parameter logic [START_W-1:0] START_CODE = 8'b1110_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              line_start,
  input  logic              acq_en,
  input  logic              hb_valid,
  input  logic              hb_data,
  output logic              bit_stb,
  output logic              bit_val,
  output logic              bit_err,
  output logic [BIDX_W-1:0] bit_idx,
  output logic              word_end
);
  localparam int SC_W = (START_W > 1) ? $clog2(START_W) : 1;

  rx_state_t            state;
  logic [SC_W-1:0]      sc_idx;
  logic [START_W-1:0]   code_sr;
  logic [BIDX_W-1:0]    bcnt;
  logic                 have_first;
  logic                 first_half;

  wire line_hit = line_start && (line_num == LINE_W'(WSS_LINE)) && acq_en;
  wire code_ok  = (hb_data == code_sr[START_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sc_idx     <= '0;
      code_sr    <= '0;
      bcnt       <= '0;
      have_first <= 1'b0;
      first_half <= 1'b0;
    end else if (line_start) begin
      state      <= line_hit ? ST_START : ST_IDLE;
      sc_idx     <= '0;
      code_sr    <= START_CODE;
      bcnt       <= '0;
      have_first <= 1'b0;
    end else if (hb_valid) begin
      unique case (state)
        ST_START: begin
          if (!code_ok) begin
            state <= ST_IDLE;
          end else if (sc_idx == SC_W'(START_W - 1)) begin
            state <= ST_DATA;
          end else begin
            sc_idx  <= sc_idx + 1'b1;
            code_sr <= code_sr << 1;
          end
        end
        ST_DATA: begin
          if (!have_first) begin
            first_half <= hb_data;
            have_first <= 1'b1;
          end else begin
            have_first <= 1'b0;
            bcnt       <= bcnt + 1'b1;
            if (bcnt == BIDX_W'(NBITS - 1)) state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign bit_stb  = (state == ST_DATA) && hb_valid && have_first && !line_start;
  assign bit_val  = first_half;
  assign bit_err  = (first_half == hb_data);
  assign bit_idx  = bcnt;
  assign word_end = bit_stb && (bcnt == BIDX_W'(NBITS - 1));

  AST_START_ONLY_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && $past(state) != ST_START) |-> $past(line_hit)); // R1

  AST_BIT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (bit_idx < BIDX_W'(NBITS))); // R2

  AST_DATA_AFTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_START) |-> $past(hb_valid && code_ok)); // R7
endmodule

// File: rtl/wss_group_acc.sv
module wss_group_acc
  import wss_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_stb,
  input  logic               bit_val,
  input  logic               bit_err,
  input  logic [BIDX_W-1:0]  bit_idx,
  input  logic               word_end,
  output logic [NBITS-1:0]   shadow_bits,
  output logic [NGROUPS-1:0] shadow_err,
  output logic               word_done
);
  wire [1:0] grp_now  = group_of(bit_idx);
  wire       head_now = group_head(bit_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_bits <= '0;
      shadow_err  <= '0;
      word_done   <= 1'b0;
    end else begin
      word_done <= word_end;
      if (bit_stb) begin
        shadow_bits[bit_idx] <= bit_val;
        if (head_now) shadow_err[grp_now] <= bit_err;
        else          shadow_err[grp_now] <= shadow_err[grp_now] | bit_err;
      end
    end
  end

  AST_GROUP_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && bit_err) |=> shadow_err[$past(grp_now)]); // R4

  AST_HEAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && head_now && !bit_err) |=> !shadow_err[$past(grp_now)]); // R4
endmodule

// File: rtl/wss_decoder.sv
module wss_decoder
  import wss_pkg::*;
#(
  parameter int             LINE_W     = 10,
  parameter int             WSS_LINE   = 23,
  parameter int             START_W    = 8,
  parameter logic [START_W-1:0] START_CODE = 8'b1110_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              line_start,
  input  logic              acq_en,
  input  logic              hb_valid,
  input  logic              hb_data,
  input  logic              flag_clr,
  output logic [7:0]        fmt_reg,
  output logic [7:0]        svc_reg,
  output logic [7:0]        sub_reg,
  output logic              wss_seen
);
  logic                 bit_stb, bit_val, bit_err, word_end, word_done;
  logic [BIDX_W-1:0]    bit_idx;
  logic [NBITS-1:0]     shadow_bits;
  logic [NGROUPS-1:0]   shadow_err;
  logic [3*REG_W-1:0]   regs_q;

  wss_frame_rx #(
    .LINE_W(LINE_W), .WSS_LINE(WSS_LINE), .START_W(START_W), .START_CODE(START_CODE)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .line_start(line_start),
    .acq_en(acq_en), .hb_valid(hb_valid), .hb_data(hb_data),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_err(bit_err),
    .bit_idx(bit_idx), .word_end(word_end)
  );

  wss_group_acc u_acc (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .bit_err(bit_err), .bit_idx(bit_idx), .word_end(word_end),
    .shadow_bits(shadow_bits), .shadow_err(shadow_err), .word_done(word_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q   <= '0;
      wss_seen <= 1'b0;
    end else begin
      if (word_done) regs_q <= pack_regs(shadow_bits, shadow_err);
      if (word_done)     wss_seen <= 1'b1;
      else if (flag_clr) wss_seen <= 1'b0;
    end
  end

  assign fmt_reg = regs_q[7:0];
  assign svc_reg = regs_q[15:8];
  assign sub_reg = regs_q[23:16];

  AST_REGS_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(word_done) |-> $stable(regs_q)); // R8

  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wss_seen) |-> $past(word_done)); // R6

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !word_done) |=> !wss_seen); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> wss_seen); // R6
endmodule

// File: tb/wss_decoder_test.sv
module wss_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] line_num = '0;
  logic       line_start = 1'b0, acq_en = 1'b0, hb_valid = 1'b0, hb_data = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] fmt_reg, svc_reg, sub_reg;
  logic       wss_seen;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_regs = '0;

  localparam logic [7:0] CODE = 8'b1110_0100;

  typedef struct packed {
    logic [9:0]  ln;
    logic        en;
    logic        good;
    logic [13:0] w;
    logic [13:0] e;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{10'd23, 1'b1, 1'b1, 14'h1A5B, 14'h0000},  // R2 R3 plain word
    '{10'd23, 1'b1, 1'b1, 14'h3FFF, 14'h0011},  // R4 groups 0 and 1 broken
    '{10'd22, 1'b1, 1'b1, 14'h0123, 14'h0000},  // R1 wrong line
    '{10'd23, 1'b0, 1'b1, 14'h0F0F, 14'h0000},  // R5 disabled
    '{10'd23, 1'b1, 1'b0, 14'h0AAA, 14'h0000},  // R7 bad start code
    '{10'd23, 1'b1, 1'b1, 14'h0000, 14'h2100},  // R4 groups 2 and 3 broken
    '{10'd23, 1'b1, 1'b1, 14'h2C3D, 14'h0000}   // R3 fresh word clears errors
  };

  wss_decoder uut (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .line_start(line_start),
    .acq_en(acq_en), .hb_valid(hb_valid), .hb_data(hb_data), .flag_clr(flag_clr),
    .fmt_reg(fmt_reg), .svc_reg(svc_reg), .sub_reg(sub_reg), .wss_seen(wss_seen)
  );

  always #10 clk = ~clk;

  function automatic logic [23:0] model(input logic [13:0] w, input logic [13:0] e);
    logic g0, g1, g2, g3;
    g0 = |e[3:0];
    g1 = |e[7:4];
    g2 = |e[10:8];
    g3 = |e[13:11];
    return {g3, w[13:11], g2, w[10:8], 3'b000, g1, w[7:4], 3'b000, g0, w[3:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half(input logic v);
    @(negedge clk); hb_valid = 1'b1; hb_data = v;
    @(negedge clk); hb_valid = 1'b0;
  endtask

  // one line: start strobe, start code, nb data bits
  task automatic send_line(input vec_t v, input int nb, input logic hold_clr);
    @(negedge clk);
    line_num = v.ln; acq_en = v.en; line_start = 1'b1; flag_clr = hold_clr;
    @(negedge clk); line_start = 1'b0;
    for (int i = 7; i >= 0; i--) half((!v.good && i == 4) ? ~CODE[i] : CODE[i]);
    for (int i = 0; i < nb; i++) begin
      half(v.w[i]);
      half(v.e[i] ? v.w[i] : ~v.w[i]);
    end
    @(negedge clk); flag_clr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 regs", {sub_reg, svc_reg, fmt_reg}, 24'h0);
    check("R9 flag", wss_seen, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic hit;
      pulse_clr();
      send_line(VT[k], 14, 1'b0);
      hit = (VT[k].ln == 10'd23) && VT[k].en && VT[k].good;
      if (hit) exp_regs = model(VT[k].w, VT[k].e);
      check($sformatf("R1 R2 R3 R4 R5 R7 vec%0d regs", k), {sub_reg, svc_reg, fmt_reg}, exp_regs);
      check($sformatf("R6 vec%0d flag", k), wss_seen, hit);
    end

    // R6: clear pulse after a capture
    pulse_clr();
    @(negedge clk);
    check("R6 cleared", wss_seen, 1'b0);

    // R6: clear held through the capture edge, capture wins
    send_line('{10'd23, 1'b1, 1'b1, 14'h1234, 14'h0000}, 14, 1'b1);
    exp_regs = model(14'h1234, 14'h0);
    check("R6 set wins flag", wss_seen, 1'b1);
    check("R6 set wins regs", {sub_reg, svc_reg, fmt_reg}, exp_regs);

    // R8: truncated word, then a new line strobe
    pulse_clr();
    send_line('{10'd23, 1'b1, 1'b1, 14'h3E01, 14'h0000}, 10, 1'b0);
    @(negedge clk); line_num = 10'd24; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 truncated regs", {sub_reg, svc_reg, fmt_reg}, exp_regs);
    check("R8 truncated flag", wss_seen, 1'b0);

    // R8: exact update edge, two edges after the last half-bit
    pulse_clr();
    @(negedge clk); line_num = 10'd23; acq_en = 1'b1; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    for (int i = 7; i >= 0; i--) half(CODE[i]);
    for (int i = 0; i < 14; i++) begin
      half(i[0]);
      if (i == 13) begin
        @(negedge clk); hb_valid = 1'b1; hb_data = ~i[0];
        @(negedge clk); hb_valid = 1'b0;
        check("R8 before update", {sub_reg, svc_reg, fmt_reg}, exp_regs);
        @(negedge clk);
        check("R8 at update", {sub_reg, svc_reg, fmt_reg}, model(14'h2AAA, 14'h0));
        check("R8 flag at update", wss_seen, 1'b1);
      end else begin
        half(~i[0]);
      end
    end

    // R9: reset mid-use returns to zero
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R9 re-reset regs", {sub_reg, svc_reg, fmt_reg}, 24'h0);
    check("R9 re-reset flag", wss_seen, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule